// File: doc/BRIEF.md
# Chip-Select Idle Release Timer

This block decides when the external chip select of a serial memory controller is let go while the controller runs in its memory-mapped mode. While an access is running the chip select is held low. It stays low after the access so that a following access to nearby data can reuse the open device transaction. A 16-bit counter measures the idle clock cycles that follow. When the programmed idle limit is reached, the chip select is released, a sticky timeout flag is raised, and an interrupt is raised if it is enabled.

The bus decoder upstream pulses `access_i` whenever a memory-mapped access is using the device. Software controls the mode field, the timeout enable, the limit, the global enable, abort and the interrupt enable. When the timeout is disabled, the chip select stays low until the controller is aborted, disabled, or switched out of memory-mapped mode.

Top module: `cs_idle_timeout`

## Requirements
- R1: Only the memory-mapped mode, `mode_i == 2'b11`, activates the block. In any other mode `cs_n_o` is high one edge later, accesses are ignored, and no timeout occurs.
- R2: With `tmo_en_i` set and a limit L, the edge after each sampled access holds `cs_n_o` low. It stays low through L idle edges and rises on the edge that ends idle cycle L+1.
- R3: With `tmo_en_i` clear, `cs_n_o` stays low after an access for any number of idle cycles.
- R4: `irq_o` is high only when `tmo_flag_o` and `irq_en_i` are both high. It follows `irq_en_i` while the flag is set.
- R5: An access sampled while the chip select is held restarts the idle count from zero.
- R6: `tmo_flag_o` goes high on the edge where a timeout releases the chip select and stays high until `flag_clr_i` is sampled. If a set and a clear fall on the same edge, the set wins.
- R7: Sampling `abort_i` high or `enable_i` low raises `cs_n_o` on the next edge, clears the idle count, and does not set the flag.
- R8: A limit of zero releases the chip select on the first idle edge after the access.
- R9: An access sampled on the edge where the limit would expire keeps `cs_n_o` low and sets no flag.
- R10: After a synchronous reset, `cs_n_o` is high and `tmo_flag_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Functional mode, 2'b11 = memory-mapped |
| tmo_en_i | input | 1 | Idle timeout enable |
| tmo_limit_i | input | 16 | Idle cycles tolerated before release |
| access_i | input | 1 | High while a memory-mapped access uses the device |
| enable_i | input | 1 | Controller enable |
| abort_i | input | 1 | Abort request |
| irq_en_i | input | 1 | Timeout interrupt enable |
| flag_clr_i | input | 1 | Clears the timeout flag |
| cs_n_o | output | 1 | Active-low chip select |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Timeout interrupt |

## Verification
Two pairs of events can land on the same clock edge. In the first, a fresh access arrives on the very edge where the idle count reaches its limit. The bench provokes this by asserting `access_i` exactly L+1 cycles after the previous access ended. It then judges that the chip select stays low, the flag stays clear, and a complete new idle window follows. In the second, the clear strobe coincides with the flag being set. The bench drives `flag_clr_i` during the expiring edge with a zero limit and expects the flag to read high afterwards.

// File: rtl/cs_timeout_pkg.sv
package cs_timeout_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        FM_WRITE  = 2'b00,
        FM_READ   = 2'b01,
        FM_POLL   = 2'b10,
        FM_MAPPED = 2'b11
    } fmode_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_BUSY   = 2'b01,
        ST_LINGER = 2'b10
    } cs_state_e;

    typedef struct packed {
        logic cnt_clear;
        logic cnt_inc;
        logic expire;
    } cnt_ctl_t;

    function automatic logic is_mapped(input logic [1:0] m);
        return fmode_e'(m) == FM_MAPPED;
    endfunction

endpackage

// File: rtl/cs_tmo_counter.sv
module cs_tmo_counter #(
    parameter int W = cs_timeout_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q >= limit);
endmodule

// File: rtl/cs_tmo_fsm.sv
module cs_tmo_fsm
    import cs_timeout_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go_off,
    input  logic      access,
    input  logic      tmo_en,
    input  logic      at_limit,
    output cnt_ctl_t  ctl,
    output cs_state_e state
);
    cs_state_e state_q, state_d;
    logic      idle_tick;

    assign idle_tick = (state_q != ST_OFF) && !access;

    always_comb begin
        ctl.expire    = !go_off && idle_tick && tmo_en && at_limit;
        ctl.cnt_clear = go_off || access || (state_q == ST_OFF) || ctl.expire;
        ctl.cnt_inc   = idle_tick && !ctl.cnt_clear;

        if (go_off) begin
            state_d = ST_OFF;
        end else if (access) begin
            state_d = ST_BUSY;
        end else if (state_q == ST_OFF || ctl.expire) begin
            state_d = ST_OFF;
        end else begin
            state_d = ST_LINGER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/cs_tmo_flag.sv
module cs_tmo_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cs_idle_timeout.sv
module cs_idle_timeout
    import cs_timeout_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_i,
    input  logic         tmo_en_i,
    input  logic [W-1:0] tmo_limit_i,
    input  logic         access_i,
    input  logic         enable_i,
    input  logic         abort_i,
    input  logic         irq_en_i,
    input  logic         flag_clr_i,
    output logic         cs_n_o,
    output logic         tmo_flag_o,
    output logic         irq_o
);
    cnt_ctl_t  ctl;
    cs_state_e state;
    logic      at_limit;
    logic      go_off;

    assign go_off = abort_i || !enable_i || !is_mapped(mode_i);

    cs_tmo_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .go_off   (go_off),
        .access   (access_i),
        .tmo_en   (tmo_en_i),
        .at_limit (at_limit),
        .ctl      (ctl),
        .state    (state)
    );

    cs_tmo_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.cnt_clear),
        .inc      (ctl.cnt_inc),
        .limit    (tmo_limit_i),
        .at_limit (at_limit)
    );

    cs_tmo_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (ctl.expire),
        .clr  (flag_clr_i),
        .flag (tmo_flag_o)
    );

    assign cs_n_o = (state == ST_OFF);
    assign irq_o  = tmo_flag_o && irq_en_i;
endmodule

// File: rtl/cs_idle_timeout_chk.sv
module cs_idle_timeout_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode_i,
    input logic         tmo_en_i,
    input logic [W-1:0] tmo_limit_i,
    input logic         access_i,
    input logic         enable_i,
    input logic         abort_i,
    input logic         irq_en_i,
    input logic         flag_clr_i,
    input logic         cs_n_o,
    input logic         tmo_flag_o,
    input logic         irq_o
);
    logic live;
    assign live = enable_i && !abort_i && mode_i == 2'b11;

    assert_mode_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'b11) |=> cs_n_o);

    assert_hold_open_R3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !tmo_en_i && live) |=> !cs_n_o);

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (tmo_flag_o && irq_en_i));

    assert_access_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (access_i && live) |=> !cs_n_o);

    assert_flag_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag_o) |-> $rose(cs_n_o));

    assert_abort_release_R7: assert property (@(posedge clk) disable iff (rst)
        (abort_i || !enable_i) |=> (cs_n_o && !$rose(tmo_flag_o)));

    assert_zero_limit_R8: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !access_i && tmo_en_i && tmo_limit_i == '0 && live) |=> cs_n_o);
endmodule

bind cs_idle_timeout cs_idle_timeout_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cs_idle_timeout.sv
module sim_cs_idle_timeout;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'b11;
    logic        tmo_en_i = 1'b1;
    logic [15:0] tmo_limit_i = 16'd3;
    logic        access_i = 1'b0;
    logic        enable_i = 1'b1;
    logic        abort_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic        cs_n_o, tmo_flag_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cs_idle_timeout u0 (.*);

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        abort_i = 1'b1; flag_clr_i = 1'b1;
        tick();
        abort_i = 1'b0; flag_clr_i = 1'b0;
        tick();
    endtask

    task automatic pulse_access();
        access_i = 1'b1;
        tick();
        access_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 cs_n after reset", cs_n_o, 1'b1);
        check("R10 flag after reset", tmo_flag_o, 1'b0);
        check("R10 irq after reset", irq_o, 1'b0);
    endtask

    task automatic t_basic();
        settle();
        tmo_limit_i = 16'd3; irq_en_i = 1'b1;
        pulse_access();
        check("R2 held after access", cs_n_o, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R2 held during idle", cs_n_o, 1'b0);
        end
        tick();
        check("R2 released at limit", cs_n_o, 1'b1);
        check("R6 flag set on release", tmo_flag_o, 1'b1);
        check("R4 irq with enable", irq_o, 1'b1);
    endtask

    task automatic t_irq_mask();
        irq_en_i = 1'b0;
        #0.1;
        check("R4 irq masked", irq_o, 1'b0);
        check("R6 flag sticky", tmo_flag_o, 1'b1);
        tick(); tick();
        check("R6 flag stays until clear", tmo_flag_o, 1'b1);
        flag_clr_i = 1'b1;
        tick();
        flag_clr_i = 1'b0;
        check("R6 flag cleared", tmo_flag_o, 1'b0);
        irq_en_i = 1'b1;
        #0.1;
        check("R4 irq low with flag clear", irq_o, 1'b0);
    endtask

    task automatic t_disabled();
        settle();
        tmo_en_i = 1'b0; tmo_limit_i = 16'd0;
        pulse_access();
        for (int i = 0; i < 50; i++) tick();
        check("R3 held with timeout off", cs_n_o, 1'b0);
        check("R3 no flag with timeout off", tmo_flag_o, 1'b0);
        tmo_en_i = 1'b1;
    endtask

    task automatic t_mode();
        settle();
        mode_i = 2'b01; tmo_limit_i = 16'd0;
        pulse_access();
        check("R1 cs idle outside mapped mode", cs_n_o, 1'b1);
        tick();
        check("R1 no flag outside mapped mode", tmo_flag_o, 1'b0);
        mode_i = 2'b11;
        pulse_access();
        check("R1 mapped mode holds", cs_n_o, 1'b0);
        mode_i = 2'b10;
        tick();
        check("R1 leaving mapped mode releases", cs_n_o, 1'b1);
        check("R1 leaving mode sets no flag", tmo_flag_o, 1'b0);
        mode_i = 2'b11;
    endtask

    task automatic t_reload();
        settle();
        tmo_limit_i = 16'd5;
        pulse_access();
        for (int i = 0; i < 3; i++) tick();
        pulse_access();
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R5 reload keeps cs held", cs_n_o, 1'b0);
        end
        tick();
        check("R5 release after full window", cs_n_o, 1'b1);
    endtask

    task automatic t_abort();
        settle();
        tmo_en_i = 1'b0;
        pulse_access();
        tick();
        abort_i = 1'b1;
        tick();
        abort_i = 1'b0;
        check("R7 abort releases", cs_n_o, 1'b1);
        check("R7 abort sets no flag", tmo_flag_o, 1'b0);
        pulse_access();
        check("R7 held before disable", cs_n_o, 1'b0);
        enable_i = 1'b0;
        tick();
        enable_i = 1'b1;
        check("R7 disable releases", cs_n_o, 1'b1);
        tmo_en_i = 1'b1; tmo_limit_i = 16'd1;
        pulse_access();
        tick();
        abort_i = 1'b1;
        tick();
        abort_i = 1'b0;
        pulse_access();
        tick();
        check("R7 count reset by abort", cs_n_o, 1'b0);
        tick();
        check("R7 full window after abort", cs_n_o, 1'b1);
    endtask

    task automatic t_zero();
        settle();
        tmo_limit_i = 16'd0;
        pulse_access();
        check("R8 held after access", cs_n_o, 1'b0);
        tick();
        check("R8 zero limit releases at once", cs_n_o, 1'b1);
        check("R8 flag on zero limit", tmo_flag_o, 1'b1);
    endtask

    task automatic t_collide_access();
        settle();
        tmo_limit_i = 16'd2;
        pulse_access();
        tick(); tick();
        access_i = 1'b1;
        tick();
        access_i = 1'b0;
        check("R9 access beats expiry", cs_n_o, 1'b0);
        check("R9 no flag on collision", tmo_flag_o, 1'b0);
        tick(); tick();
        check("R9 new window still held", cs_n_o, 1'b0);
        tick();
        check("R9 new window expires", cs_n_o, 1'b1);
    endtask

    task automatic t_collide_flag();
        settle();
        tmo_limit_i = 16'd0;
        pulse_access();
        flag_clr_i = 1'b1;
        tick();
        flag_clr_i = 1'b0;
        check("R6 set wins over clear", tmo_flag_o, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        tick();
        rst = 1'b0;
        t_reset();
        tick();
        t_basic();
        t_irq_mask();
        t_disabled();
        t_mode();
        t_reload();
        t_abort();
        t_zero();
        t_collide_access();
        t_collide_flag();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule